// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes characters from a serial link on which an external master owns the clock. The block watches the master's clock line, brings it and the data line into the local clock domain through two-flop synchronizers, and captures one data bit on every falling edge of the serial clock, least significant bit first. Once a whole character (eight bits, or nine when the wide-character select is on) is captured, it is written into a two-entry receive queue. A completion flag, an interrupt request and, in low-power state, a wake request follow from the queue contents.

Control inputs select the mode and enable reception. The host pops characters through a read strobe and sees the oldest queued character, its ninth bit and the status flags directly on the outputs. Characters that arrive while the queue is full are lost and raise a sticky overrun flag. That flag also stops reception until the host drops the continuous-receive enable or the port enable.

Top module: `sync_slave_rx`

## Requirements
- R1: A character is captured only when `port_en` and `sync_mode` are 1 and `clk_src_master` is 0; in any other setting no character enters the queue.
- R2: Capture also needs `cont_rx_en` at 1. `single_rx_en` has no effect on any output in any setting.
- R3: A data bit is taken on each falling edge of `ser_clk`, least significant bit first. In 8-bit mode the eight bits appear on `rd_data[7:0]`.
- R4: With `rx9_en` at 1 a character is nine bits long, and the ninth (last received) bit appears on `rd_bit9`. In 8-bit mode `rd_bit9` reads 0.
- R5: `rx_done` rises on the fourth `clk` rising edge after the final falling edge of `ser_clk` of a character reaches the input, if the queue was empty. It stays 1 while the queue holds any character.
- R6: The queue holds two characters and delivers the oldest first. A 1 on `rd_en` at a rising edge removes the head entry. `rd_en` on an empty queue changes nothing.
- R7: `irq` is 1 exactly when `rx_done` and `rx_int_en` are both 1.
- R8: When a character completes while the queue holds two entries and no read takes place in that cycle, `overrun` becomes 1 and the character is discarded. While `overrun` is 1, further characters are not accepted.
- R9: `overrun` stays 1 until `cont_rx_en` or `port_en` is 0 at a rising edge. Clearing it through `cont_rx_en` keeps the queued characters.
- R10: `port_en` at 0 empties the queue, clears `overrun` and discards a partly received character. The next character is received whole.
- R11: `wake_req` is 1 when `low_power`, `rx_int_en` and `rx_done` are all 1. Reception continues while `low_power` is 1.
- R12: A character that completes in the same cycle as a read from a full queue is accepted, and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Port enable; 0 resets the receiver |
| sync_mode | input | 1 | 1 selects synchronous operation |
| clk_src_master | input | 1 | 1 selects internal clock source (master); 0 for slave |
| cont_rx_en | input | 1 | Continuous-receive enable |
| single_rx_en | input | 1 | Single-receive enable; ignored in slave operation |
| rx9_en | input | 1 | 1 selects nine-bit characters |
| rx_int_en | input | 1 | Receive interrupt enable |
| low_power | input | 1 | Device is in low-power state |
| ser_clk | input | 1 | Serial clock from the master, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Low eight bits of the head character |
| rd_bit9 | output | 1 | Ninth bit of the head character |
| rx_done | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt request |
| wake_req | output | 1 | Wake request in low-power state |

## Verification
The completion of a character and a host read can land on the same rising edge. When the queue is full, that meeting decides whether the character is kept or an overrun is flagged. The bench measures the fixed latency from the last serial falling edge to the queue write. It then fills the queue, sends a third character and raises `rd_en` for exactly the edge on which that character is written. After that it expects `overrun` at 0, the second character at the head and the new character behind it. A second run without the read shows the opposite outcome: overrun set and the character lost.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

    localparam int DATA_W = 8;
    localparam int CHAR_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(CHAR_W + 1);

    typedef logic [CNT_W-1:0] bit_cnt_t;

    typedef struct packed {
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    // Index of the final bit of a character for the selected length
    function automatic bit_cnt_t last_bit(input logic nine);
        return nine ? bit_cnt_t'(CHAR_W - 1) : bit_cnt_t'(DATA_W - 1);
    endfunction

endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_clk,
    input  logic ser_data,
    output logic fall,
    output logic bit_out
);
    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] dt_q;
    logic              ck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q    <= '1;
            dt_q    <= '0;
            ck_last <= 1'b1;
        end else begin
            ck_q    <= {ck_q[STAGES-2:0], ser_clk};
            dt_q    <= {dt_q[STAGES-2:0], ser_data};
            ck_last <= ck_q[STAGES-1];
        end
    end

    assign fall    = ck_last & ~ck_q[STAGES-1];
    assign bit_out = dt_q[STAGES-1];

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift
    import ssrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     nine,
    input  logic     fall,
    input  logic     bit_in,
    output logic     char_vld,
    output rx_char_t char_out
);
    bit_cnt_t          cnt;
    logic [CHAR_W-1:0] sr;
    logic [CHAR_W-1:0] whole;

    always_comb begin
        whole      = sr;
        whole[cnt] = bit_in;
        if (!nine) whole[CHAR_W-1] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt      <= '0;
            char_vld <= 1'b0;
        end else begin
            char_vld <= 1'b0;
            if (fall) begin
                if (cnt == last_bit(nine)) begin
                    char_out <= rx_char_t'(whole);
                    char_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    sr[cnt]  <= bit_in;
                    cnt      <= cnt + 1'b1;
                end
            end
        end
    end

    // R3: a completed character always follows a sampled falling edge
    assert_vld_after_fall_R3: assert property (@(posedge clk) disable iff (rst)
        char_vld |-> $past(fall));

    // R10: disabling the receiver leaves no completion behind
    assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !char_vld);

endmodule

// File: rtl/ssrx_fifo.sv
module ssrx_fifo
    import ssrx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     ovr_clr,
    input  logic     push,
    input  rx_char_t din,
    input  logic     pop,
    output rx_char_t head,
    output logic     not_empty,
    output logic     overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rx_char_t        mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            pop_ok, push_ok, ovr_set;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && !overrun && ((count != FULL) || pop_ok);
    assign ovr_set = push && !overrun && (count == FULL) && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            if (ovr_clr)      overrun <= 1'b0;
            else if (ovr_set) overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);

    // R8: overrun only ever rises out of a full queue
    assert_ovr_from_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(count) == FULL);

    // R9: overrun holds while neither clearing condition is present
    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr && !clr) |=> overrun);

    // R10: a port disable leaves the queue empty
    assert_clr_empties_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0) && !overrun);

    // R6: a read of an empty queue with no write keeps it empty
    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push) |=> count == '0);

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
    import ssrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              cont_rx_en,
    input  logic              single_rx_en,
    input  logic              rx9_en,
    input  logic              rx_int_en,
    input  logic              low_power,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rx_done,
    output logic              overrun,
    output logic              irq,
    output logic              wake_req
);
    logic     slave_on, rx_gate, fall, bit_s, char_vld;
    rx_char_t char_w, head;
    logic     unused_single_rx = single_rx_en;

    assign slave_on = port_en && sync_mode && !clk_src_master;
    assign rx_gate  = slave_on && cont_rx_en && !overrun;

    ssrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .fall(fall), .bit_out(bit_s)
    );

    ssrx_shift u_shift (
        .clk(clk), .rst(rst), .enable(rx_gate), .nine(rx9_en),
        .fall(fall), .bit_in(bit_s), .char_vld(char_vld), .char_out(char_w)
    );

    ssrx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(!port_en), .ovr_clr(!cont_rx_en),
        .push(char_vld), .din(char_w), .pop(rd_en),
        .head(head), .not_empty(rx_done), .overrun(overrun)
    );

    assign rd_data  = head.data;
    assign rd_bit9  = head.bit9;
    assign irq      = rx_done && rx_int_en;
    assign wake_req = irq && low_power;

    // R1: outside slave operation no character is produced
    assert_idle_no_char_R1: assert property (@(posedge clk) disable iff (rst)
        !slave_on |=> !char_vld);

    // R5: the queue only becomes non-empty from a completed character
    assert_done_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> $past(char_vld));

endmodule

// File: tb/sync_slave_rx_tb.sv
module sync_slave_rx_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b0, sync_mode = 1'b1, clk_src_master = 1'b0;
    logic       cont_rx_en = 1'b1, single_rx_en = 1'b0, rx9_en = 1'b0;
    logic       rx_int_en = 1'b0, low_power = 1'b0;
    logic       ser_clk = 1'b1, ser_data = 1'b0, rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rx_done, overrun, irq, wake_req;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [8:0] mq [2];
    int         mn  = 0;
    bit         movr = 0;

    always #5 clk = ~clk;

    sync_slave_rx u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
        .clk_src_master(clk_src_master), .cont_rx_en(cont_rx_en),
        .single_rx_en(single_rx_en), .rx9_en(rx9_en), .rx_int_en(rx_int_en),
        .low_power(low_power), .ser_clk(ser_clk), .ser_data(ser_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .rx_done(rx_done), .overrun(overrun), .irq(irq), .wake_req(wake_req)
    );

    function automatic bit gate_model();
        return port_en && sync_mode && !clk_src_master && cont_rx_en && !movr;
    endfunction

    function automatic logic [8:0] shape(input logic [8:0] w, input logic nine);
        return nine ? w : {1'b0, w[7:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " rx_done"}, int'(rx_done), int'(mn != 0));
        chk({req, " overrun"}, int'(overrun), int'(movr));
        chk({req, " irq R7"}, int'(irq), int'((mn != 0) && rx_int_en));
        chk({req, " wake R11"}, int'(wake_req), int'((mn != 0) && rx_int_en && low_power));
        if (mn != 0) begin
            chk({req, " data"}, int'(rd_data), int'(mq[0][7:0]));
            chk({req, " bit9"}, int'(rd_bit9), int'(mq[0][8]));
        end
    endtask

    // Each task starts and ends 1 ns after a rising clock edge
    task automatic send_bits(input logic [8:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i];
            ser_clk  = 1'b1;
            repeat (3) @(posedge clk);
            #1 ser_clk = 1'b0;
            repeat (3) @(posedge clk);
            #1;
        end
        ser_clk = 1'b1;
    endtask

    task automatic model_push(input logic [8:0] w, input logic nine, input bit popped);
        if (!gate_model()) return;
        if (mn < 2 || popped) begin
            mq[mn] = shape(w, nine);
            mn++;
        end else begin
            movr = 1;
        end
    endtask

    task automatic model_pop();
        if (mn != 0) begin
            mq[0] = mq[1];
            mn--;
        end
    endtask

    // Send a whole character, let it settle, update the model
    task automatic send_char(input logic [8:0] w);
        logic nine = rx9_en;
        send_bits(w, nine ? 9 : 8);
        repeat (2) @(posedge clk);
        #1;
        model_push(w, nine, 1'b0);
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        model_pop();
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b0;
        @(posedge clk);
        #1 sig = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state
        check_state("reset R6");
        port_en = 1'b1;
        @(posedge clk); #1;

        // R3: 8-bit character, LSB first
        send_char(9'h0A5);
        check_state("8-bit R3");
        do_read();
        check_state("pop R6");
        do_read();
        check_state("pop empty R6");

        // R4: nine-bit character
        rx9_en = 1'b1;
        send_char(9'h15A);
        check_state("9-bit R4");
        do_read();
        rx9_en = 1'b0;

        // R5: latency from last serial fall to rx_done
        send_bits(9'h03C, 8);
        chk("latency before R5", int'(rx_done), 0);
        @(posedge clk); #1;
        chk("latency edge R5", int'(rx_done), 1);
        model_push(9'h03C, 1'b0, 1'b0);
        check_state("latency data R5");
        do_read();

        // R1: master clock source or async mode -> nothing captured
        clk_src_master = 1'b1;
        send_char(9'h0FF);
        check_state("master src R1");
        clk_src_master = 1'b0;
        sync_mode = 1'b0;
        send_char(9'h0FF);
        check_state("async R1");
        sync_mode = 1'b1;

        // R2: no capture without cont_rx_en; single_rx_en ignored
        cont_rx_en = 1'b0;
        single_rx_en = 1'b1;
        send_char(9'h011);
        check_state("no cont R2");
        cont_rx_en = 1'b1;
        send_char(9'h0C3);
        check_state("single ignored R2");
        single_rx_en = 1'b0;
        do_read();

        // R7/R11: interrupt and wake
        rx_int_en = 1'b1;
        low_power = 1'b1;
        send_char(9'h077);
        check_state("wake R11");
        rx_int_en = 1'b0;
        #1 check_state("irq off R7");
        low_power = 1'b0;
        do_read();

        // R8: overrun on third character, then ignored
        send_char(9'h001);
        send_char(9'h002);
        send_char(9'h003);
        check_state("overrun R8");
        send_char(9'h004);
        check_state("ignored R8");
        // R9: clear via cont_rx_en keeps queue
        pulse(cont_rx_en);
        movr = 0;
        check_state("ovr clear R9");

        // R12: completion meets read on full queue
        send_bits(9'h0E1, 8);
        rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        model_pop();
        model_push(9'h0E1, 1'b0, 1'b0);
        @(posedge clk); #1;
        check_state("same cycle R12");
        do_read();
        check_state("same cycle next R12");

        // R10: port disable empties queue and drops partial char
        send_bits(9'h1FF, 3);
        pulse(port_en);
        mn = 0;
        movr = 0;
        check_state("port clr R10");
        send_char(9'h096);
        check_state("after partial R10");
        do_read();

        // R9: port disable clears overrun
        send_char(9'h021);
        send_char(9'h022);
        send_char(9'h023);
        check_state("overrun again R8");
        pulse(port_en);
        mn = 0;
        movr = 0;
        check_state("port clears ovr R9");

        // constrained random traffic
        for (int it = 0; it < 60; it++) begin
            rx9_en    = 1'($urandom_range(0, 1));
            rx_int_en = 1'($urandom_range(0, 1));
            w = 9'($urandom_range(0, 511));
            send_char(w);
            check_state("random R3 R4 R6");
            for (int r = 0; r < int'($urandom_range(0, 2)); r++) begin
                do_read();
                check_state("random read R6");
            end
            if (movr) begin
                pulse(cont_rx_en);
                movr = 0;
                check_state("random ovr clr R9");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule